// File: doc/BRIEF.md
# Double-Buffered Programmable Clock Divider

This block divides its input clock by a 15-bit ratio. A down counter loads the ratio, counts to zero and raises a one-cycle terminal pulse. It then reloads and starts the next period. A half-rate square wave toggles on every terminal pulse, so a test point can watch the divided frequency at a 50 % duty cycle.

Ratio updates come from a bus receiver that does not share the divider clock. The bus places the ratio word on `ratio_i` and raises `wr_i`. The strobe passes through a two-flop synchronizer. Its rising edge captures the word, clamped to the minimum legal ratio, into a first holding stage and marks it as pending. The second stage holds the active ratio. It takes the pending value only at the counter's terminal count, so the period in progress always finishes with the ratio it started with.

Top module: `ratio_divider`

## Requirements
- R1: After `rst_ni` is released, `ratio_o` is 256, `half_o` is 0 and `tc_o` is 0. The counter starts at 255, so the first terminal pulse is seen after 255 rising edges.
- R2: `tc_o` is high for exactly one cycle in every period. The number of cycles between two consecutive terminal pulses equals `ratio_o`.
- R3: The ratio is the plain unsigned binary value of `ratio_i[14:0]`, with bit 14 as MSB. The largest ratio, 32767, is accepted unchanged.
- R4: A written value below 17 (including 0) becomes 17.
- R5: A ratio word written with `wr_i` becomes active at the first terminal count after its capture. `wr_i` must stay high for at least 3 clocks, and `ratio_i` must stay stable while `wr_i` is high.
- R6: A write made in the middle of a period does not change the length of that period.
- R7: `ratio_o` changes only on the clock edge that ends a terminal-count cycle.
- R8: `half_o` toggles once per terminal pulse and holds its value otherwise.
- R9: Changes on `ratio_i` without a rising edge on `wr_i` have no effect on `ratio_o` or on the period.
- R10: If several writes are captured before one terminal count, only the last one becomes active.
- R11: The counter value stays below the active ratio and, outside a terminal cycle, decreases by one each clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 15 | Ratio word from the bus side |
| wr_i | input | 1 | Write strobe from the bus side (asynchronous) |
| tc_o | output | 1 | One-cycle terminal pulse, once per period |
| half_o | output | 1 | Divided output, further divided by two |
| ratio_o | output | 15 | Active ratio held in the second stage |

## Verification
The bound checker checks the following on every clock:
- the minimum-ratio floor;
- that the active ratio changes only at a terminal count;
- the toggle rule of the half-rate output;
- that the counter decrements, stays in bounds and reloads to the new ratio minus one.

Other behaviours need timed write scenarios, so only the bench can show them:
- the actual period lengths;
- the reset-to-first-pulse delay;
- that a mid-period write leaves the running period intact;
- that the last of several writes wins;
- that ratio changes without a strobe are ignored.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;
  localparam int unsigned RATIO_W     = 15;
  localparam int unsigned MIN_RATIO   = 17;
  localparam int unsigned RESET_RATIO = 256;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  // STAGES flops for metastability, one more for edge detection
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], strobe_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/ratio_stage.sv
module ratio_stage #(
  parameter int unsigned RATIO_W     = 15,
  parameter int unsigned MIN_RATIO   = 17,
  parameter int unsigned RESET_RATIO = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               capture_i,
  input  logic               wrap_i,
  output logic [RATIO_W-1:0] active_o,
  output logic [RATIO_W-1:0] next_o
);
  localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] INIT  = RATIO_W'(RESET_RATIO);

  logic [RATIO_W-1:0] staged_q, active_q, clamped;
  logic               pending_q;

  assign clamped = (ratio_i < FLOOR) ? FLOOR : ratio_i;
  assign next_o  = pending_q ? staged_q : active_q;

  // first stage: bus side, captured on synchronized strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q  <= INIT;
      pending_q <= 1'b0;
    end else if (capture_i) begin
      staged_q  <= clamped;
      pending_q <= 1'b1;
    end else if (wrap_i) begin
      pending_q <= 1'b0;
    end
  end

  // second stage: updated only at the counter wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= INIT;
    else if (wrap_i) active_q <= next_o;
  end

  assign active_o = active_q;
endmodule

// File: rtl/down_counter.sv
module down_counter #(
  parameter int unsigned RATIO_W     = 15,
  parameter int unsigned RESET_RATIO = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] reload_i,
  output logic               tc_o,
  output logic               half_o,
  output logic [RATIO_W-1:0] count_o
);
  localparam logic [RATIO_W-1:0] INIT = RATIO_W'(RESET_RATIO - 1);

  logic [RATIO_W-1:0] cnt_q;
  logic               half_q;

  assign tc_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= INIT;
      half_q <= 1'b0;
    end else if (tc_o) begin
      cnt_q  <= reload_i - 1'b1;
      half_q <= ~half_q;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign half_o  = half_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider
  import ratio_div_pkg::*;
#(
  parameter int unsigned W       = RATIO_W,
  parameter int unsigned MIN_R   = MIN_RATIO,
  parameter int unsigned RESET_R = RESET_RATIO,
  parameter int unsigned SYNC_N  = SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  input  logic         wr_i,
  output logic         tc_o,
  output logic         half_o,
  output logic [W-1:0] ratio_o
);
  logic         capture;
  logic [W-1:0] next_ratio;
  logic [W-1:0] cnt;

  strobe_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(wr_i),
    .rise_o  (capture)
  );

  ratio_stage #(.RATIO_W(W), .MIN_RATIO(MIN_R), .RESET_RATIO(RESET_R)) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ratio_i  (ratio_i),
    .capture_i(capture),
    .wrap_i   (tc_o),
    .active_o (ratio_o),
    .next_o   (next_ratio)
  );

  down_counter #(.RATIO_W(W), .RESET_RATIO(RESET_R)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(next_ratio),
    .tc_o    (tc_o),
    .half_o  (half_o),
    .count_o (cnt)
  );
endmodule

// File: rtl/ratio_divider_chk.sv
module ratio_divider_chk #(
  parameter int unsigned W     = 15,
  parameter int unsigned MIN_R = 17
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tc_i,
  input logic         half_i,
  input logic [W-1:0] ratio_i,
  input logic [W-1:0] cnt_i
);
  localparam logic [W-1:0] FLOOR = W'(MIN_R);

  AST_RATIO_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_i >= FLOOR); // R4

  AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_i |=> $stable(ratio_i)); // R7

  AST_HALF_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i |=> (half_i != $past(half_i))); // R8

  AST_HALF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_i |=> $stable(half_i)); // R8

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < ratio_i); // R11

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_i |=> (cnt_i == $past(cnt_i) - 1'b1)); // R11

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i |=> (cnt_i == ratio_i - 1'b1)); // R2
endmodule

bind ratio_divider ratio_divider_chk #(.W(W), .MIN_R(MIN_R)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tc_i   (tc_o),
  .half_i (half_o),
  .ratio_i(ratio_o),
  .cnt_i  (cnt)
);

// File: tb/ratio_divider_test.sv
module ratio_divider_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] ratio_i = '0;
  logic        wr_i = 1'b0;
  logic        tc_o, half_o;
  logic [14:0] ratio_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  ratio_divider uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ratio_i(ratio_i),
    .wr_i   (wr_i),
    .tc_o   (tc_o),
    .half_o (half_o),
    .ratio_o(ratio_o)
  );

  // {written value, expected active ratio}
  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {15'd100, 15'd100}, {15'd17,  15'd17},  {15'd5,   15'd17},
    {15'd0,   15'd17},  {15'd18,  15'd18},  {15'd300, 15'd300},
    {15'd16,  15'd17},  {15'd1234,15'd1234}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  // returns at the negedge where tc_o is high
  task automatic wait_tc();
    do @(negedge clk_i); while (!tc_o);
  endtask

  // call at a tc negedge; returns cycles to the next tc
  task automatic period(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tc_o);
  endtask

  // consumes exactly 5 negedges
  task automatic write_ratio(input logic [14:0] v);
    ratio_i = v;
    wr_i    = 1'b1;
    repeat (4) @(negedge clk_i);
    wr_i    = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    int n;
    logic h0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(ratio_o == 15'd256, "R1 ratio", ratio_o, 256);
    chk(half_o == 1'b0, "R1 half", half_o, 0);
    chk(tc_o == 1'b0, "R1 tc", tc_o, 0);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tc_o);
    chk(n == 255, "R1 first pulse", n, 255);
    period(n);
    chk(n == 256, "R1 R2 reset period", n, 256);

    // table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      write_ratio(VEC[i][29:15]);
      wait_tc();
      @(negedge clk_i);
      chk(ratio_o == VEC[i][14:0], "R5 R4 active ratio", ratio_o, VEC[i][14:0]);
      wait_tc();
      h0 = half_o;
      period(n);
      chk(n == int'(VEC[i][14:0]), "R2 period", n, VEC[i][14:0]);
      chk(half_o == ~h0, "R8 half toggle", half_o, ~h0);
    end

    // R6: mid-period write keeps current period
    write_ratio(15'd200);
    wait_tc();
    wait_tc();
    write_ratio(15'd50);
    n = 5;
    do begin @(negedge clk_i); n++; end while (!tc_o);
    chk(n == 200, "R6 running period", n, 200);
    period(n);
    chk(n == 50, "R6 R5 next period", n, 50);

    // R9: ratio_i changes without strobe ignored
    ratio_i = 15'd999;
    period(n);
    chk(n == 50, "R9 period", n, 50);
    ratio_i = 15'd20;
    period(n);
    chk(n == 50, "R9 period2", n, 50);
    chk(ratio_o == 15'd50, "R9 ratio", ratio_o, 50);

    // R10: last write before terminal count wins
    write_ratio(15'd400);
    wait_tc();
    wait_tc();
    write_ratio(15'd40);
    write_ratio(15'd60);
    wait_tc();
    @(negedge clk_i);
    chk(ratio_o == 15'd60, "R10 ratio", ratio_o, 60);
    wait_tc();
    period(n);
    chk(n == 60, "R10 period", n, 60);

    // R3: maximum ratio
    write_ratio(15'd32767);
    wait_tc();
    @(negedge clk_i);
    chk(ratio_o == 15'd32767, "R3 max ratio", ratio_o, 32767);
    wait_tc();
    period(n);
    chk(n == 32767, "R3 max period", n, 32767);

    // R7: ratio_o stable within a period after a capture
    write_ratio(15'd25);
    chk(ratio_o == 15'd32767, "R7 hold until wrap", ratio_o, 32767);

    finish_run();
  end
endmodule